// File: doc/BRIEF.md
# Hybrid SAR / Sigma-Delta Conversion Sequencer

This block is the digital control for one channel of a two-step data converter. A conversion begins with a coarse successive-approximation search over a small capacitor DAC. The block then hands the leftover residue to an oversampled sigma-delta loop. It takes one comparator decision per clock. From these decisions it drives the DAC trial code, the loop-filter enable and reset, and the sign of the sigma-delta feedback reference. It also emits a per-cycle modulator bit stream for a downstream decimator and latches the coarse code.

The sequencer is a four-state machine. `ST_IDLE` goes to `ST_SEARCH` on an accepted start (transition *launch*). `ST_SEARCH` goes to `ST_RESIDUE` after the last coarse bit (transition *handoff*). `ST_RESIDUE` goes to `ST_DONE` after the last residue clock (transition *finish*). `ST_DONE` goes back to `ST_IDLE` unconditionally (transition *release*). The analog DAC, comparator and loop filter are outside the block, and so is the decimation of the bit stream. With the default sizes, 6 coarse bits and 44 residue clocks, a conversion takes 50 clocks, which is 10 µs at 5 MHz. At a 25 kHz sample rate the converter is therefore busy for a quarter of each period. The residue phase adds 4 bits to the coarse result, which gives a 10-bit word after decimation.

Top module: `hsd_conv_seq`

## Requirements
- R1: A `start_i` pulse sampled while `idle_o` is high begins a conversion. On the next cycle `idle_o` is low and `dac_code_o` holds only its MSB set (100000 for 6 bits).
- R2: The search lasts COARSE_BITS cycles and tests one bit per cycle, MSB first. `cmp_i`=1 means the input is at or above the present trial code, and the tested bit is kept. `cmp_i`=0 clears the tested bit. The next lower bit is set as the new trial, so the final code equals the input value.
- R3: During the residue phase `lf_en_o`=1 and `lf_rst_o`=0. In every other state `lf_en_o`=0 and `lf_rst_o`=1, so the integrators are held in reset during the search.
- R4: `fb_sel_o` is common mode (2'b00) in idle, search and done, and in the first residue cycle.
- R5: From the second residue cycle on, `fb_sel_o` is +reference (2'b01) if the previous cycle's `cmp_i` was 1, and −reference (2'b10) if it was 0.
- R6: The residue phase lasts RESID_CYCLES cycles. `done_o` is high for exactly one cycle, which begins COARSE_BITS+RESID_CYCLES clocks after the accepting edge.
- R7: `mod_valid_o` is high for exactly RESID_CYCLES cycles per conversion, each one cycle after a residue cycle. `mod_bit_o` equals that residue cycle's `cmp_i`.
- R8: `coarse_o` takes the final search code when the search ends and holds it through idle and through the whole next search.
- R9: `start_i` during search, residue or done has no effect. The conversion runs its normal length, and after done the block sits in idle with `dac_code_o` unchanged.
- R10: `idle_o` is high exactly when no conversion or done cycle is in progress.
- R11: After reset the block is idle: `done_o`, `mod_valid_o`, `lf_en_o`=0, `lf_rst_o`=1, `fb_sel_o`=00, and `coarse_o`, `dac_code_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, honoured only in idle |
| cmp_i | input | 1 | Comparator decision for the present cycle |
| dac_code_o | output | COARSE_BITS | Trial code to the capacitor DAC |
| lf_en_o | output | 1 | Loop-filter enable |
| lf_rst_o | output | 1 | Loop-filter integrator reset |
| fb_sel_o | output | 2 | Feedback reference: 00 common mode, 01 +ref, 10 −ref |
| mod_bit_o | output | 1 | Modulator bit for the decimator |
| mod_valid_o | output | 1 | Qualifies `mod_bit_o` |
| coarse_o | output | COARSE_BITS | Latched coarse code |
| done_o | output | 1 | One-cycle end-of-conversion strobe |
| idle_o | output | 1 | Converter free; the capacitor array may be used for sampling |

## Verification
Relative to the edge that accepts a start, search trial k (k = 0..5) is visible in cycle k+1. Residue cycle r is visible in cycle 7+r, and `done_o` in cycle 51. A decision applied in one cycle shows on `fb_sel_o`, `mod_bit_o` and `mod_valid_o` in the next. The bench changes `cmp_i` and `start_i` at falling edges and reads every output at the falling edge before it drives the next value, so each check sits in the cycle where its result is due. It sweeps all 64 coarse input values under three residue decision patterns, and injects busy-time starts in two of the conversions.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SEARCH  = 2'd1,
        ST_RESIDUE = 2'd2,
        ST_DONE    = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        FB_CM  = 2'b00,
        FB_POS = 2'b01,
        FB_NEG = 2'b10
    } fb_sel_t;

endpackage

// File: rtl/hsd_down_ctr.sv
// Loadable down counter that saturates at zero; shared by both phases.
module hsd_down_ctr #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic [CW-1:0] cnt_o,
    output logic          zero_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/hsd_sar_reg.sv
// Successive-approximation trial register and coarse-code latch.
module hsd_sar_reg #(
    parameter int W  = 6,
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic          step_i,
    input  logic [IW-1:0] idx_i,
    input  logic          cmp_i,
    output logic [W-1:0]  trial_o,
    output logic [W-1:0]  coarse_o
);
    localparam logic [W-1:0] FIRST_TRIAL = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] trial_q;
    logic [W-1:0] trial_nxt;
    logic [W-1:0] coarse_q;

    always_comb begin
        trial_nxt = trial_q;
        for (int i = 0; i < W; i++) begin
            if (i == int'(idx_i)) begin
                trial_nxt[i] = cmp_i;
            end else if (i + 1 == int'(idx_i)) begin
                trial_nxt[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial_q  <= '0;
            coarse_q <= '0;
        end else begin
            if (init_i) begin
                trial_q <= FIRST_TRIAL;
            end else if (step_i) begin
                trial_q <= trial_nxt;
            end
            if (step_i && idx_i == '0) begin
                coarse_q <= trial_nxt;
            end
        end
    end

    assign trial_o  = trial_q;
    assign coarse_o = coarse_q;
endmodule

// File: rtl/hsd_sd_fb.sv
// Residue-phase feedback sign and modulator bit stream.
module hsd_sd_fb
    import hsd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active_i,
    input  logic       cmp_i,
    output logic [1:0] fb_sel_o,
    output logic       mod_bit_o,
    output logic       mod_valid_o
);
    logic sign_q;
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sign_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            armed_q <= active_i;
            if (active_i) begin
                sign_q <= cmp_i;
            end
        end
    end

    always_comb begin
        if (active_i && armed_q) begin
            fb_sel_o = sign_q ? FB_POS : FB_NEG;
        end else begin
            fb_sel_o = FB_CM;
        end
    end

    assign mod_bit_o   = sign_q;
    assign mod_valid_o = armed_q;
endmodule

// File: rtl/hsd_conv_seq.sv
module hsd_conv_seq
    import hsd_pkg::*;
#(
    parameter int COARSE_BITS  = 6,
    parameter int RESID_CYCLES = 44
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   cmp_i,
    output logic [COARSE_BITS-1:0] dac_code_o,
    output logic                   lf_en_o,
    output logic                   lf_rst_o,
    output logic [1:0]             fb_sel_o,
    output logic                   mod_bit_o,
    output logic                   mod_valid_o,
    output logic [COARSE_BITS-1:0] coarse_o,
    output logic                   done_o,
    output logic                   idle_o
);
    localparam int MAX_LEN = (COARSE_BITS > RESID_CYCLES) ? COARSE_BITS : RESID_CYCLES;
    localparam int CW      = $clog2(MAX_LEN + 1);
    localparam logic [CW-1:0] SEARCH_LOAD = CW'(COARSE_BITS - 1);
    localparam logic [CW-1:0] RESID_LOAD  = CW'(RESID_CYCLES - 1);

    seq_state_t    state_q, state_nxt;
    logic          ld;
    logic [CW-1:0] ld_val;
    logic [CW-1:0] cnt;
    logic          cnt_zero;
    logic          in_search;
    logic          in_resid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Next state and counter loads
    always_comb begin
        state_nxt = state_q;
        ld        = 1'b0;
        ld_val    = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_nxt = ST_SEARCH;
                    ld        = 1'b1;
                    ld_val    = SEARCH_LOAD;
                end
            end
            ST_SEARCH: begin
                if (cnt_zero) begin
                    state_nxt = ST_RESIDUE;
                    ld        = 1'b1;
                    ld_val    = RESID_LOAD;
                end
            end
            ST_RESIDUE: begin
                if (cnt_zero) begin
                    state_nxt = ST_DONE;
                end
            end
            ST_DONE: begin
                state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        in_search = 1'b0;
        in_resid  = 1'b0;
        done_o    = 1'b0;
        idle_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:    idle_o    = 1'b1;
            ST_SEARCH:  in_search = 1'b1;
            ST_RESIDUE: in_resid  = 1'b1;
            ST_DONE:    done_o    = 1'b1;
            default:    idle_o    = 1'b1;
        endcase
        lf_en_o  = in_resid;
        lf_rst_o = !in_resid;
    end

    hsd_down_ctr #(.CW(CW)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ld),
        .load_val_i (ld_val),
        .cnt_o      (cnt),
        .zero_o     (cnt_zero)
    );

    hsd_sar_reg #(.W(COARSE_BITS), .IW(CW)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_i   (idle_o && start_i),
        .step_i   (in_search),
        .idx_i    (cnt),
        .cmp_i    (cmp_i),
        .trial_o  (dac_code_o),
        .coarse_o (coarse_o)
    );

    hsd_sd_fb u_fb (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (in_resid),
        .cmp_i       (cmp_i),
        .fb_sel_o    (fb_sel_o),
        .mod_bit_o   (mod_bit_o),
        .mod_valid_o (mod_valid_o)
    );
endmodule

// File: rtl/hsd_conv_seq_chk.sv
module hsd_conv_seq_chk #(
    parameter int COARSE_BITS = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic                   cmp_i,
    input logic [COARSE_BITS-1:0] dac_code_o,
    input logic                   lf_en_o,
    input logic                   lf_rst_o,
    input logic [1:0]             fb_sel_o,
    input logic                   mod_bit_o,
    input logic                   mod_valid_o,
    input logic [COARSE_BITS-1:0] coarse_o,
    input logic                   done_o,
    input logic                   idle_o
);
    localparam logic [COARSE_BITS-1:0] MSB_ONLY = {1'b1, {(COARSE_BITS-1){1'b0}}};

    p_launch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o && start_i |=> !idle_o && dac_code_o == MSB_ONLY);

    p_idle_lf_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> lf_rst_o && !lf_en_o);

    p_fb_cm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !lf_en_o |-> fb_sel_o == 2'b00);

    p_fb_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lf_en_o && $past(lf_en_o) |-> fb_sel_o == ($past(cmp_i) ? 2'b01 : 2'b10));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_modbit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mod_valid_o |-> $past(lf_en_o) && mod_bit_o == $past(cmp_i));

    p_coarse_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o && !start_i |=> $stable(coarse_o));

    p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_o && !done_o |=> !idle_o);

    p_done_to_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> idle_o);
endmodule

bind hsd_conv_seq hsd_conv_seq_chk #(.COARSE_BITS(COARSE_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cmp_i       (cmp_i),
    .dac_code_o  (dac_code_o),
    .lf_en_o     (lf_en_o),
    .lf_rst_o    (lf_rst_o),
    .fb_sel_o    (fb_sel_o),
    .mod_bit_o   (mod_bit_o),
    .mod_valid_o (mod_valid_o),
    .coarse_o    (coarse_o),
    .done_o      (done_o),
    .idle_o      (idle_o)
);

// File: tb/hsd_conv_seq_bench.sv
`timescale 1ns/1ps
module hsd_conv_seq_bench;
    localparam int NB = 6;
    localparam int NR = 44;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          cmp_i = 1'b0;
    logic [NB-1:0] dac_code_o;
    logic          lf_en_o;
    logic          lf_rst_o;
    logic [1:0]    fb_sel_o;
    logic          mod_bit_o;
    logic          mod_valid_o;
    logic [NB-1:0] coarse_o;
    logic          done_o;
    logic          idle_o;

    int checks = 0;
    int errors = 0;
    int last_coarse = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hsd_conv_seq #(.COARSE_BITS(NB), .RESID_CYCLES(NR)) u_hsd_conv_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
        .dac_code_o(dac_code_o), .lf_en_o(lf_en_o), .lf_rst_o(lf_rst_o),
        .fb_sel_o(fb_sel_o), .mod_bit_o(mod_bit_o), .mod_valid_o(mod_valid_o),
        .coarse_o(coarse_o), .done_o(done_o), .idle_o(idle_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int pat_bit(input int vin, input int r, input int mode);
        case (mode)
            0:       return ((vin * 37 + r * 11) >> 2) & 1;
            1:       return 1;
            default: return r & 1;
        endcase
    endfunction

    task automatic run_conv(input int vin, input bit ign, input int mode);
        int prev;
        check("R10 idle before start", idle_o, 1);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < NB; k++) begin
            int idx = NB - 1 - k;
            int exp_trial = ((vin >> (idx + 1)) << (idx + 1)) | (1 << idx);
            check("R1/R2 trial code", dac_code_o, exp_trial);
            check("R3 lf_en in search", lf_en_o, 0);
            check("R3 lf_rst in search", lf_rst_o, 1);
            check("R4 fb common mode in search", fb_sel_o, 0);
            check("R8 coarse held over search", coarse_o, last_coarse);
            check("R10 busy in search", idle_o, 0);
            start_i = (ign && k == 3);
            cmp_i = (vin >= dac_code_o);
            @(negedge clk);
        end
        prev = 0;
        for (int r = 0; r < NR; r++) begin
            int b = pat_bit(vin, r, mode);
            check("R2 final code on dac", dac_code_o, vin);
            check("R8 coarse latched", coarse_o, vin);
            check("R3 lf_en in residue", lf_en_o, 1);
            check("R3 lf_rst in residue", lf_rst_o, 0);
            if (r == 0) check("R4 fb cm first residue", fb_sel_o, 0);
            else        check("R5 fb sign", fb_sel_o, prev ? 1 : 2);
            check("R7 mod_valid", mod_valid_o, (r > 0) ? 1 : 0);
            if (r > 0) check("R7 mod_bit", mod_bit_o, prev);
            check("R6 no early done", done_o, 0);
            check("R10 busy in residue", idle_o, 0);
            start_i = (ign && r == 10);
            cmp_i = b[0];
            prev = b;
            @(negedge clk);
        end
        check("R6 done strobe", done_o, 1);
        check("R7 last mod_valid", mod_valid_o, 1);
        check("R7 last mod_bit", mod_bit_o, prev);
        check("R4 fb cm in done", fb_sel_o, 0);
        check("R3 lf_rst in done", lf_rst_o, 1);
        check("R10 busy in done", idle_o, 0);
        start_i = ign;
        cmp_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        check("R6 done one cycle", done_o, 0);
        check("R7 mod_valid ends", mod_valid_o, 0);
        check("R10 idle after done", idle_o, 1);
        check("R9 dac unchanged after ignored start", dac_code_o, vin);
        check("R8 coarse after conversion", coarse_o, vin);
        last_coarse = vin;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 idle", idle_o, 1);
        check("R11 done", done_o, 0);
        check("R11 mod_valid", mod_valid_o, 0);
        check("R11 lf_en", lf_en_o, 0);
        check("R11 lf_rst", lf_rst_o, 1);
        check("R11 fb", fb_sel_o, 0);
        check("R11 coarse", coarse_o, 0);
        check("R11 dac", dac_code_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int v = 0; v < (1 << NB); v++) begin
            run_conv(v, (v == 5 || v == 40), v % 3);
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule